// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a byte-addressed serial EEPROM target for a two-wire bus, built as synchronous logic. It runs on a fast system clock that oversamples the bus clock and data lines, finds start and stop conditions and clock edges, and pulls the data line low only through an open-drain enable. The device address word is checked against a fixed prefix and three strap inputs. A two-byte word address follows. Byte writes, page writes, current-address reads, random reads and sequential reads are all supported.

Write data is collected in a one-page staging buffer. After a stop, a self-timed write cycle of a parameterized number of system clocks begins. The staged bytes enter the storage array when that cycle finishes. While the cycle runs, the slave gives no acknowledge, so a master can poll with its device address to find out when the cycle is over. A protect input blocks array updates. Pages hold 64 bytes. Writes wrap inside their page, while reads continue across the whole array.

Top module: `eeprom_twi_slave`

## Requirements
- R1: Start is data falling while clock is high, and stop is data rising while clock is high. The slave changes its data-line enable only after a clock fall, a start or a stop. The enable is released after reset.
- R2: The device word is `1010`, then three bits that must equal `dev_sel_i[2:0]`, then the direction bit (1 = read). On a match the slave pulls data low in the ninth clock. On a mismatch it stays silent for every later byte until the next start.
- R3: After a write-mode device word, the slave takes a high address byte and then a low address byte, and acknowledges both. The pointer is the low `ADDR_W` bits of that 16-bit value, and the bits above are ignored.
- R4: A stop on a byte boundary after one or more write data bytes starts a write cycle. When the cycle ends, the data can be read back at the addressed locations.
- R5: Each data byte goes to the current pointer, and then only the low six pointer bits advance. A 65th byte therefore lands at the start of the same 64-byte page and overwrites what was written there.
- R6: While a write cycle runs, the slave acknowledges nothing, not even its own device word. After the cycle it acknowledges its device word again.
- R7: While `wp_i` is high at the stop, the slave still acknowledges the address and data bytes and still advances the pointer. The array stays unchanged and no write cycle starts, so the next device word is acknowledged at once.
- R8: A random read (device word for write, two address bytes, repeated start, device word for read) returns the byte at the loaded address.
- R9: The pointer holds the last accessed location plus one. A current-address read returns the byte there.
- R10: In a read, each master acknowledge makes the slave send the next byte, and the address wraps from the last array byte to byte 0. A master non-acknowledge ends the transfer.
- R11: A stop that arrives partway through a data byte discards the staged data. Memory is not changed, no write cycle starts, and the pointer keeps the loaded word address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls the data line low |
| dev_sel_i | input | 3 | Strapped device select bits |
| wp_i | input | 1 | Write protect; high blocks array updates |

## Verification
The bench builds the slave with `ADDR_W = 7`, which gives a 128-byte array of two pages, and with `WR_CYCLES = 300`. Because the array is this small, a sequential read runs past the last byte and wraps to byte 0 within a few dozen bytes. A page write of 70 bytes then shows the in-page wrap next to a second page that stays untouched. The short write cycle is still longer than one polling transfer. The first poll after a stop therefore falls inside the busy window, and a later poll falls after it.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

  localparam int PAGE_BYTES = 64;
  localparam int PAGE_AW    = 6;
  localparam logic [3:0] DEV_PREFIX = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_AHI,
    ST_AHI_ACK,
    ST_ALO,
    ST_ALO_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_WAIT
  } twi_state_e;

endpackage

// File: rtl/eeprom_line_sync.sv
module eeprom_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o,
  output logic sda_o
);

  logic [2:0] scl_r;
  logic [2:0] sda_r;
  logic       scl_now, scl_old, sda_now, sda_old;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_r <= 3'b111;
      sda_r <= 3'b111;
    end else begin
      scl_r <= {scl_r[1:0], scl_i};
      sda_r <= {sda_r[1:0], sda_i};
    end
  end

  assign scl_now = scl_r[1];
  assign scl_old = scl_r[2];
  assign sda_now = sda_r[1];
  assign sda_old = sda_r[2];

  assign scl_rise_o = scl_now & ~scl_old;
  assign scl_fall_o = ~scl_now & scl_old;
  assign start_o    = scl_now & scl_old & sda_old & ~sda_now;
  assign stop_o     = scl_now & scl_old & ~sda_old & sda_now;
  assign sda_o      = sda_now;

endmodule

// File: rtl/eeprom_page_buf.sv
module eeprom_page_buf
  import eeprom_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr_i,
  input  logic                      we_i,
  input  logic [PAGE_AW-1:0]        idx_i,
  input  logic [7:0]                wdata_i,
  output logic [PAGE_BYTES*8-1:0]   data_o,
  output logic [PAGE_BYTES-1:0]     mask_o
);

  logic [7:0]            ent [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_q, mask_n;

  always_ff @(posedge clk) begin
    if (we_i) ent[idx_i] <= wdata_i;
  end

  always_comb begin
    mask_n = mask_q;
    if (clr_i) begin
      mask_n = '0;
    end else if (we_i) begin
      mask_n[idx_i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_n;
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_out
    assign data_o[g*8 +: 8] = ent[g];
  end

  assign mask_o = mask_q;

endmodule

// File: rtl/eeprom_array.sv
module eeprom_array
  import eeprom_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic                        clk,
  input  logic                        commit_i,
  input  logic [ADDR_W-PAGE_AW-1:0]   page_i,
  input  logic [PAGE_BYTES*8-1:0]     data_i,
  input  logic [PAGE_BYTES-1:0]       mask_i,
  input  logic [ADDR_W-1:0]           rd_addr_i,
  output logic [7:0]                  rd_data_o
);

  localparam int NUM_PAGES = 1 << (ADDR_W - PAGE_AW);

  logic [ADDR_W-PAGE_AW-1:0] rd_page;
  logic [PAGE_AW-1:0]        rd_off;
  logic [PAGE_BYTES*8-1:0]   rd_cols;

  assign rd_page = rd_addr_i[ADDR_W-1:PAGE_AW];
  assign rd_off  = rd_addr_i[PAGE_AW-1:0];

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_col
    logic [7:0] col [NUM_PAGES];
    always_ff @(posedge clk) begin
      if (commit_i && mask_i[g]) col[page_i] <= data_i[g*8 +: 8];
    end
    assign rd_cols[g*8 +: 8] = col[rd_page];
  end

  assign rd_data_o = rd_cols[{rd_off, 3'b000} +: 8];

endmodule

// File: rtl/eeprom_twi_slave.sv
module eeprom_twi_slave
  import eeprom_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int WR_CYCLES = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] dev_sel_i,
  input  logic       wp_i
);

  localparam int CNT_W  = $clog2(WR_CYCLES + 1);
  localparam int PAGE_W = ADDR_W - PAGE_AW;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ns = rst_sync[1];

  logic ev_rise, ev_fall, ev_start, ev_stop, sda_s;

  eeprom_line_sync i_sync (
    .clk        (clk),
    .rst_n      (rst_ns),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (ev_rise),
    .scl_fall_o (ev_fall),
    .start_o    (ev_start),
    .stop_o     (ev_stop),
    .sda_o      (sda_s)
  );

  twi_state_e           state_q, state_n;
  logic [3:0]           cnt_q, cnt_n;
  logic [7:0]           sh_q, sh_n;
  logic [7:0]           ahi_q, ahi_n;
  logic                 oe_q, oe_n;
  logic                 rw_q, rw_n;
  logic                 mack_q, mack_n;
  logic                 have_q, have_n;
  logic                 busy_q, busy_n;
  logic [CNT_W-1:0]     bcnt_q, bcnt_n;
  logic [ADDR_W-1:0]    ptr_q, ptr_n;
  logic                 buf_we, buf_clr, commit;
  logic [15:0]          word_addr;
  logic [7:0]           rd_data;
  logic [2:0]           tx_idx;
  logic [PAGE_BYTES*8-1:0] buf_data;
  logic [PAGE_BYTES-1:0]   buf_mask;
  logic                 unused_addr_bits;

  assign word_addr        = {ahi_q, sh_q};
  assign unused_addr_bits = ^word_addr;
  assign tx_idx           = ~cnt_q[2:0];

  eeprom_page_buf i_buf (
    .clk     (clk),
    .rst_n   (rst_ns),
    .clr_i   (buf_clr),
    .we_i    (buf_we),
    .idx_i   (ptr_q[PAGE_AW-1:0]),
    .wdata_i (sh_q),
    .data_o  (buf_data),
    .mask_o  (buf_mask)
  );

  eeprom_array #(.ADDR_W(ADDR_W)) i_array (
    .clk       (clk),
    .commit_i  (commit),
    .page_i    (ptr_q[ADDR_W-1:PAGE_AW]),
    .data_i    (buf_data),
    .mask_i    (buf_mask),
    .rd_addr_i (ptr_q),
    .rd_data_o (rd_data)
  );

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    ahi_n   = ahi_q;
    oe_n    = oe_q;
    rw_n    = rw_q;
    mack_n  = mack_q;
    have_n  = have_q;
    busy_n  = busy_q;
    bcnt_n  = bcnt_q;
    ptr_n   = ptr_q;
    buf_we  = 1'b0;
    buf_clr = 1'b0;
    commit  = 1'b0;

    // self-timed write cycle
    if (busy_q) begin
      if (bcnt_q == '0) begin
        busy_n  = 1'b0;
        commit  = 1'b1;
        buf_clr = 1'b1;
      end else begin
        bcnt_n = bcnt_q - 1'b1;
      end
    end

    if (ev_start) begin
      state_n = ST_DEV;
      cnt_n   = '0;
      oe_n    = 1'b0;
      if (!busy_q) begin
        have_n  = 1'b0;
        buf_clr = 1'b1;
      end
    end else if (ev_stop) begin
      state_n = ST_IDLE;
      cnt_n   = '0;
      oe_n    = 1'b0;
      if (!busy_q) begin
        have_n = 1'b0;
        if (state_q == ST_WR && cnt_q <= 4'd1 && have_q && !wp_i) begin
          busy_n = 1'b1;
          bcnt_n = CNT_W'(WR_CYCLES - 1);
        end else begin
          buf_clr = 1'b1;
        end
      end
    end else begin
      unique case (state_q)
        ST_DEV, ST_AHI, ST_ALO, ST_WR: begin
          if (ev_rise && cnt_q < 4'd8) begin
            sh_n  = {sh_q[6:0], sda_s};
            cnt_n = cnt_q + 1'b1;
          end else if (ev_fall && cnt_q == 4'd8) begin
            cnt_n = '0;
            oe_n  = 1'b1;
            case (state_q)
              ST_DEV: begin
                if (sh_q[7:4] == DEV_PREFIX && sh_q[3:1] == dev_sel_i && !busy_q) begin
                  rw_n    = sh_q[0];
                  state_n = ST_DEV_ACK;
                end else begin
                  oe_n    = 1'b0;
                  state_n = ST_WAIT;
                end
              end
              ST_AHI: begin
                ahi_n   = sh_q;
                state_n = ST_AHI_ACK;
              end
              ST_ALO: begin
                ptr_n   = word_addr[ADDR_W-1:0];
                state_n = ST_ALO_ACK;
              end
              default: begin
                buf_we  = 1'b1;
                have_n  = 1'b1;
                ptr_n   = {ptr_q[ADDR_W-1:PAGE_AW], ptr_q[PAGE_AW-1:0] + 1'b1};
                state_n = ST_WR_ACK;
              end
            endcase
          end
        end
        ST_DEV_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WR_ACK: begin
          if (ev_fall) begin
            oe_n  = 1'b0;
            cnt_n = '0;
            case (state_q)
              ST_DEV_ACK: begin
                if (rw_q) begin
                  sh_n    = rd_data;
                  oe_n    = ~rd_data[7];
                  cnt_n   = 4'd1;
                  state_n = ST_RD;
                end else begin
                  state_n = ST_AHI;
                end
              end
              ST_AHI_ACK: state_n = ST_ALO;
              default:    state_n = ST_WR;
            endcase
          end
        end
        ST_RD: begin
          if (ev_fall) begin
            if (cnt_q == 4'd8) begin
              oe_n    = 1'b0;
              cnt_n   = '0;
              ptr_n   = ptr_q + 1'b1;
              state_n = ST_RD_ACK;
            end else begin
              oe_n  = ~sh_q[tx_idx];
              cnt_n = cnt_q + 1'b1;
            end
          end
        end
        ST_RD_ACK: begin
          if (ev_rise) begin
            mack_n = ~sda_s;
          end else if (ev_fall) begin
            if (mack_q) begin
              sh_n    = rd_data;
              oe_n    = ~rd_data[7];
              cnt_n   = 4'd1;
              state_n = ST_RD;
            end else begin
              oe_n    = 1'b0;
              state_n = ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      ahi_q   <= '0;
      oe_q    <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      have_q  <= 1'b0;
      busy_q  <= 1'b0;
      bcnt_q  <= '0;
      ptr_q   <= '0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      ahi_q   <= ahi_n;
      oe_q    <= oe_n;
      rw_q    <= rw_n;
      mack_q  <= mack_n;
      have_q  <= have_n;
      busy_q  <= busy_n;
      bcnt_q  <= bcnt_n;
      ptr_q   <= ptr_n;
    end
  end

  assign sda_oe_o = oe_q;

  AST_OE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_ns)
    (!$past(ev_fall) && !$past(ev_start) && !$past(ev_stop)) |-> $stable(oe_q)); // R1

  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_ns)
    (state_q == ST_WR && state_n == ST_WR_ACK) |=> $stable(ptr_q[ADDR_W-1:PAGE_AW])); // R5

  AST_SILENT_BUSY: assert property (@(posedge clk) disable iff (!rst_ns)
    busy_q |-> state_q != ST_DEV_ACK); // R6

  AST_CYCLE_ENDS: assert property (@(posedge clk) disable iff (!rst_ns)
    (busy_q && bcnt_q == '0) |=> !busy_q); // R4

  AST_WP_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(busy_q) |-> $past(!wp_i)); // R7

  AST_ABORT_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_ns)
    (ev_stop && state_q == ST_WR && cnt_q > 4'd1) |=> !busy_q); // R11

endmodule

// File: tb/test_eeprom_twi_slave.sv
module test_eeprom_twi_slave;

  localparam int AW    = 7;
  localparam int SIZE  = 1 << AW;
  localparam int WRC   = 300;
  localparam int Q     = 5;
  localparam int LIMIT = 195000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, scl_m, sda_m, wp, sda_oe, sda_line;
  logic [2:0] dev_sel;

  assign sda_line = sda_m & ~sda_oe;

  eeprom_twi_slave #(.ADDR_W(AW), .WR_CYCLES(WRC)) i_eeprom_twi_slave (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_m),
    .sda_i     (sda_line),
    .sda_oe_o  (sda_oe),
    .dev_sel_i (dev_sel),
    .wp_i      (wp)
  );

  logic [7:0] model [SIZE];
  int ptr_m;
  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (cyc == LIMIT && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements) actual expired expected done");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  function automatic int wr_loc(int a, int i);
    return (a & ~63) | ((a + i) & 63);
  endfunction

  function automatic int rd_loc(int a, int i);
    return (a + i) % SIZE;
  endfunction

  task automatic wq(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    scl_m = 1'b0; wq(Q);
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    scl_m = 1'b0; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic bit_io(input logic b, output logic r);
    scl_m = 1'b0; wq(Q);
    sda_m = b;    wq(Q);
    scl_m = 1'b1; wq(Q);
    r = sda_line; wq(Q);
    scl_m = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_io(d[i], r);
    bit_io(1'b1, r);
    ack = ~r;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, r);
      d[i] = r;
    end
    bit_io(~mack, r);
  endtask

  function automatic logic [7:0] dev_word(logic rw);
    return {4'b1010, dev_sel, rw};
  endfunction

  task automatic send_addr(input int a, input string req);
    logic ack;
    wr_byte(8'($urandom), ack);
    chk(ack, req, ack, 1);
    wr_byte({1'($urandom), 7'(a)}, ack);
    chk(ack, req, ack, 1);
  endtask

  task automatic page_write(input int a, input int n);
    logic ack;
    logic [7:0] d;
    bus_start();
    wr_byte(dev_word(1'b0), ack);
    chk(ack, "R2", ack, 1);
    send_addr(a, "R3");
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      wr_byte(d, ack);
      chk(ack, wp ? "R7" : "R3", ack, 1);
      if (!wp) model[wr_loc(a, i)] = d;
    end
    ptr_m = wr_loc(a, n);
    bus_stop();
  endtask

  task automatic poll(output logic ack);
    bus_start();
    wr_byte(dev_word(1'b0), ack);
    bus_stop();
  endtask

  task automatic wait_ready(input string req);
    logic ack;
    int tries;
    tries = 0;
    ack = 1'b0;
    while (!ack && tries < 20) begin
      poll(ack);
      tries++;
    end
    chk(ack, req, ack, 1);
  endtask

  task automatic rand_read(input int a, input int n, input string req);
    logic ack;
    logic [7:0] d;
    bus_start();
    wr_byte(dev_word(1'b0), ack);
    chk(ack, "R2", ack, 1);
    send_addr(a, "R3");
    bus_start();
    wr_byte(dev_word(1'b1), ack);
    chk(ack, "R8", ack, 1);
    for (int i = 0; i < n; i++) begin
      rd_byte(i != n - 1, d);
      chk(d === model[rd_loc(a, i)], req, d, model[rd_loc(a, i)]);
    end
    bus_stop();
    ptr_m = rd_loc(a, n);
  endtask

  task automatic cur_read(input int n, input string req);
    logic ack;
    logic [7:0] d;
    bus_start();
    wr_byte(dev_word(1'b1), ack);
    chk(ack, req, ack, 1);
    for (int i = 0; i < n; i++) begin
      rd_byte(i != n - 1, d);
      chk(d === model[rd_loc(ptr_m, i)], req, d, model[rd_loc(ptr_m, i)]);
    end
    bus_stop();
    ptr_m = rd_loc(ptr_m, n);
  endtask

  initial begin
    logic ack;
    logic r;
    int a, n;
    void'($urandom(32'd2024));
    rst_n   = 1'b0;
    scl_m   = 1'b1;
    sda_m   = 1'b1;
    wp      = 1'b0;
    dev_sel = 3'b101;
    ptr_m   = 0;
    wq(6);
    rst_n = 1'b1;
    wq(6);

    // R1: reset state, line released
    chk(sda_oe == 1'b0, "R1", sda_oe, 0);

    // R4 R6: fill page 0, poll while busy, then wait for the cycle to end
    page_write(0, 64);
    poll(ack);
    chk(!ack, "R6", ack, 0);
    wait_ready("R6");
    page_write(64, 64);
    wait_ready("R4");
    chk(sda_oe == 1'b0, "R1", sda_oe, 0);

    // R8 R10: random read that runs past the array end
    rand_read(100, 40, "R10");
    // R9: current address continues after the last byte read
    cur_read(3, "R9");

    // R2: wrong select bits, wrong prefix, then silence until next start
    bus_start();
    wr_byte({4'b1010, ~dev_sel, 1'b0}, ack);
    chk(!ack, "R2", ack, 0);
    wr_byte(8'h00, ack);
    chk(!ack, "R2", ack, 0);
    bus_start();
    wr_byte({4'b1011, dev_sel, 1'b1}, ack);
    chk(!ack, "R2", ack, 0);
    bus_start();
    wr_byte(dev_word(1'b0), ack);
    chk(ack, "R2", ack, 1);
    bus_stop();

    // R3 R4: single byte write
    a = int'($urandom % SIZE);
    page_write(a, 1);
    wait_ready("R4");
    rand_read(a, 1, "R4");

    // R5: 70 bytes from offset 60 wrap inside page 0
    page_write(60, 70);
    wait_ready("R5");
    rand_read(0, 64, "R5");
    rand_read(64, 2, "R5");

    // R7: protected write acked, no cycle, array unchanged
    wp = 1'b1;
    a = 70;
    page_write(a, 5);
    poll(ack);
    chk(ack, "R7", ack, 1);
    wp = 1'b0;
    rand_read(a, 5, "R7");

    // R11: stop in the middle of a data byte
    a = 20;
    bus_start();
    wr_byte(dev_word(1'b0), ack);
    chk(ack, "R11", ack, 1);
    send_addr(a, "R11");
    bit_io(1'b0, r);
    bit_io(1'b1, r);
    bit_io(1'b0, r);
    bus_stop();
    ptr_m = a;
    poll(ack);
    chk(ack, "R11", ack, 1);
    cur_read(1, "R11");

    // constrained random writes and read-back
    for (int k = 0; k < 8; k++) begin
      a = int'($urandom % SIZE);
      n = 1 + int'($urandom % 20);
      page_write(a, n);
      wait_ready("R4");
      rand_read(a, n, "R8");
    end
    cur_read(2, "R9");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule